// File: doc/BRIEF.md
# Centralized Multi-Probe Sample Collector

This block gathers samples from several monitor probes into one shared on-chip buffer. Each probe raises an event strobe together with a sample word. The collector latches the sample into a per-probe holding slot and marks that probe busy. A fixed-priority arbiter then moves at most one held sample per cycle into a central first-in, first-out store. Each stored entry is tagged with the index of the probe that produced it, so entries from all probes can share one store and still be told apart.

A busy probe cannot take another sample. Any event that arrives while its slot is still waiting for a grant is lost, and so is any event that arrives while the store is full. Every lost event adds one to that probe's saturating drop counter. Software can read these counters to see how much accuracy the shared store costs.

To read the store, the host raises a burst request. The collector then presents one entry per cycle, oldest first, until the store is empty. It marks the final entry of the burst, so every probe's data leaves in one contiguous transfer.

Top module: `sample_collector`

## Requirements
- R1: After reset the store is empty, `buf_full` and `rd_valid` are 0, no probe is busy, and every drop counter reads 0.
- R2: An event on a probe that is not busy, while the store is not full, latches that probe's sample. `probe_busy` for that probe is 1 from the next cycle on, until the sample is written into the store.
- R3: At most one held sample is written into the store per cycle. The winner is the busy probe with the highest rank value in `probe_rank` (a larger value wins). Among equal ranks the lowest probe index wins. The written probe is no longer busy from the next cycle.
- R4: An event on a busy probe is discarded. The held sample stays unchanged, and the probe's drop counter rises by one.
- R5: Each drop counter saturates at its all-ones value and never wraps or decreases outside reset.
- R6: `buf_full` is 1 exactly when the store holds DEPTH entries. While it is 1 no sample is written, busy probes keep their samples, and an event on a non-busy probe is dropped and counted.
- R7: Each read entry gives the sample on `rd_data` and the index of its source probe on `rd_probe`.
- R8: A burst request while the store is not empty starts a drain. From the next cycle, `rd_valid` is 1 and one entry is removed per cycle, in the order the entries were written.
- R9: `rd_last` is 1 together with the entry whose removal leaves the store empty. The drain then ends and `rd_valid` is 0 on the following cycle.
- R10: A burst request while the store is empty, or while a drain is already running, has no effect.
- R11: A write and a drain read in the same cycle both take place. A full store refuses the write even in a cycle where an entry is read out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe_evt | input | N_PROBES | Per-probe event strobe |
| probe_din | input | N_PROBES*DATA_W | Per-probe sample words, probe i in bits [i*DATA_W +: DATA_W] |
| probe_rank | input | N_PROBES*RANK_W | Per-probe priority rank, larger wins |
| burst_req | input | 1 | Request to drain the whole store |
| probe_busy | output | N_PROBES | Probe holds a sample that is not yet written |
| drop_cnt | output | N_PROBES*CNT_W | Per-probe saturating count of lost events |
| buf_full | output | 1 | Store holds DEPTH entries |
| rd_valid | output | 1 | A drained entry is presented this cycle |
| rd_data | output | DATA_W | Sample of the presented entry |
| rd_probe | output | IDX_W | Source probe index of the presented entry |
| rd_last | output | 1 | Presented entry empties the store |

## Verification
The bench builds the block with four probes, 8-bit samples, a four-entry store and 3-bit drop counters. The small store fills after a handful of events, so full-store refusal and reads that coincide with writes come up often. The narrow counters reach their saturation value within a short run. Two rank levels share a value, so both the rank ordering and the lowest-index tie rule are exercised in a single simultaneous burst of events from all four probes.

// File: rtl/smpcol_pkg.sv
package smpcol_pkg;

  typedef enum logic {
    DRN_IDLE = 1'b0,
    DRN_RUN  = 1'b1
  } drain_state_e;

  // width of an index able to address n items, never below one bit
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/smpcol_probe_slot.sv
module smpcol_probe_slot #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [DATA_W-1:0] din,
  input  logic              store_full,
  input  logic              granted,
  output logic              busy,
  output logic [DATA_W-1:0] held,
  output logic [CNT_W-1:0]  drops,
  output logic              lost
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic capture;

  assign capture = evt && !busy && !store_full;
  assign lost    = evt && (busy || store_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      held  <= '0;
      drops <= '0;
    end else begin
      if (capture) begin
        busy <= 1'b1;
        held <= din;
      end else if (granted) begin
        busy <= 1'b0;
      end
      if (lost) begin
        drops <= sat_inc(drops);
      end
    end
  end

endmodule

// File: rtl/smpcol_prio_arb.sv
module smpcol_prio_arb #(
  parameter int N_REQ  = 4,
  parameter int RANK_W = 2
) (
  input  logic [N_REQ-1:0]        req,
  input  logic [N_REQ*RANK_W-1:0] rank,
  input  logic                    enable,
  output logic [N_REQ-1:0]        grant,
  output logic                    any_grant
);

  localparam int SEL_W = smpcol_pkg::idx_bits(N_REQ);

  always_comb begin
    logic              found;
    logic [RANK_W-1:0] best;
    logic [SEL_W-1:0]  sel;
    found = 1'b0;
    best  = '0;
    sel   = '0;
    for (int i = 0; i < N_REQ; i++) begin
      // strict compare keeps the lower index on equal rank
      if (req[i] && (!found || (rank[i*RANK_W +: RANK_W] > best))) begin
        found = 1'b1;
        best  = rank[i*RANK_W +: RANK_W];
        sel   = SEL_W'(i);
      end
    end
    grant = '0;
    if (found && enable) begin
      grant[sel] = 1'b1;
    end
    any_grant = found && enable;
  end

endmodule

// File: rtl/smpcol_store.sv
module smpcol_store #(
  parameter int ENTRY_W = 18,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               burst_req,
  output logic               full,
  output logic               empty,
  output logic               rd_fire,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_last
);

  import smpcol_pkg::*;

  localparam int PTR_W = idx_bits(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [OCC_W-1:0] occ_step(input logic [OCC_W-1:0] o,
                                                input logic push,
                                                input logic pop);
    logic [OCC_W-1:0] r;
    r = o;
    if (push && !pop) r = o + 1'b1;
    if (pop && !push) r = o - 1'b1;
    return r;
  endfunction

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;
  logic [OCC_W-1:0]   occ;
  drain_state_e       drain_q;
  logic               wr_fire;

  assign full     = (occ == OCC_FULL);
  assign empty    = (occ == '0);
  assign wr_fire  = wr_en && !full;
  assign rd_fire  = (drain_q == DRN_RUN) && !empty;
  assign rd_last  = rd_fire && (occ == OCC_ONE) && !wr_fire;
  assign rd_entry = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[wr_ptr] <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      drain_q <= DRN_IDLE;
    end else begin
      if (wr_fire) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_fire) rd_ptr <= ptr_inc(rd_ptr);
      occ <= occ_step(occ, wr_fire, rd_fire);
      case (drain_q)
        DRN_IDLE: if (burst_req && !empty) drain_q <= DRN_RUN;
        DRN_RUN:  if (rd_last)             drain_q <= DRN_IDLE;
        default:                           drain_q <= DRN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sample_collector.sv
module sample_collector #(
  parameter int  N_PROBES = 4,
  parameter int  DATA_W   = 16,
  parameter int  DEPTH    = 16,
  parameter int  CNT_W    = 8,
  parameter int  RANK_W   = 2,
  localparam int IDX_W    = smpcol_pkg::idx_bits(N_PROBES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PROBES-1:0]        probe_evt,
  input  logic [N_PROBES*DATA_W-1:0] probe_din,
  input  logic [N_PROBES*RANK_W-1:0] probe_rank,
  input  logic                       burst_req,
  output logic [N_PROBES-1:0]        probe_busy,
  output logic [N_PROBES*CNT_W-1:0]  drop_cnt,
  output logic                       buf_full,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic [IDX_W-1:0]           rd_probe,
  output logic                       rd_last
);

  localparam int ENTRY_W = IDX_W + DATA_W;

  // named internal events, observed by the bound checker
  logic [N_PROBES-1:0]        grant;
  logic                       wr_fire;
  logic                       buf_empty;
  logic [N_PROBES-1:0]        lost;
  logic [N_PROBES*DATA_W-1:0] held_all;
  logic [ENTRY_W-1:0]         wr_entry;
  logic [ENTRY_W-1:0]         rd_entry;

  for (genvar g = 0; g < N_PROBES; g++) begin : g_slot
    smpcol_probe_slot #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (probe_evt[g]),
      .din        (probe_din[g*DATA_W +: DATA_W]),
      .store_full (buf_full),
      .granted    (grant[g]),
      .busy       (probe_busy[g]),
      .held       (held_all[g*DATA_W +: DATA_W]),
      .drops      (drop_cnt[g*CNT_W +: CNT_W]),
      .lost       (lost[g])
    );
  end

  smpcol_prio_arb #(
    .N_REQ  (N_PROBES),
    .RANK_W (RANK_W)
  ) u_arb (
    .req       (probe_busy),
    .rank      (probe_rank),
    .enable    (!buf_full),
    .grant     (grant),
    .any_grant (wr_fire)
  );

  // one-hot grant selects the winning slot and its index
  always_comb begin
    logic [DATA_W-1:0] sel_data;
    logic [IDX_W-1:0]  sel_idx;
    sel_data = '0;
    sel_idx  = '0;
    for (int i = 0; i < N_PROBES; i++) begin
      if (grant[i]) begin
        sel_data = sel_data | held_all[i*DATA_W +: DATA_W];
        sel_idx  = sel_idx | IDX_W'(i);
      end
    end
    wr_entry = {sel_idx, sel_data};
  end

  smpcol_store #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (DEPTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire),
    .wr_entry  (wr_entry),
    .burst_req (burst_req),
    .full      (buf_full),
    .empty     (buf_empty),
    .rd_fire   (rd_valid),
    .rd_entry  (rd_entry),
    .rd_last   (rd_last)
  );

  assign rd_data  = rd_entry[DATA_W-1:0];
  assign rd_probe = rd_entry[ENTRY_W-1 -: IDX_W];

endmodule

// File: rtl/smpcol_checker.sv
module smpcol_checker #(
  parameter int N_PROBES = 4,
  parameter int CNT_W    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_PROBES-1:0]       probe_evt,
  input logic [N_PROBES-1:0]       probe_busy,
  input logic [N_PROBES-1:0]       grant,
  input logic [N_PROBES*CNT_W-1:0] drop_cnt,
  input logic                      wr_fire,
  input logic                      buf_full,
  input logic                      buf_empty,
  input logic                      rd_valid,
  input logic                      rd_last
);

  assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !wr_fire);

  assert_read_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !buf_empty);

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_valid);

  for (genvar g = 0; g < N_PROBES; g++) begin : g_chk
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_evt[g] && !probe_busy[g] && !buf_full) |=> probe_busy[g]);

    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_busy[g] && !grant[g]) |=> probe_busy[g]);

    assert_drop_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_cnt[g*CNT_W +: CNT_W] >= $past(drop_cnt[g*CNT_W +: CNT_W])));
  end

endmodule

bind sample_collector smpcol_checker #(
  .N_PROBES (N_PROBES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .probe_evt  (probe_evt),
  .probe_busy (probe_busy),
  .grant      (grant),
  .drop_cnt   (drop_cnt),
  .wr_fire    (wr_fire),
  .buf_full   (buf_full),
  .buf_empty  (buf_empty),
  .rd_valid   (rd_valid),
  .rd_last    (rd_last)
);

// File: tb/sample_collector_bench.sv
module sample_collector_bench;

  localparam int NP  = 4;
  localparam int DW  = 8;
  localparam int DEP = 4;
  localparam int CW  = 3;
  localparam int RW  = 2;
  localparam int IW  = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    probe_evt = '0;
  logic [NP*DW-1:0] probe_din = '0;
  logic [NP*RW-1:0] probe_rank = '0;
  logic             burst_req = 1'b0;
  logic [NP-1:0]    probe_busy;
  logic [NP*CW-1:0] drop_cnt;
  logic             buf_full;
  logic             rd_valid;
  logic [DW-1:0]    rd_data;
  logic [IW-1:0]    rd_probe;
  logic             rd_last;

  always #5 clk = ~clk;

  sample_collector #(
    .N_PROBES (NP),
    .DATA_W   (DW),
    .DEPTH    (DEP),
    .CNT_W    (CW),
    .RANK_W   (RW)
  ) u_sample_collector (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_evt  (probe_evt),
    .probe_din  (probe_din),
    .probe_rank (probe_rank),
    .burst_req  (burst_req),
    .probe_busy (probe_busy),
    .drop_cnt   (drop_cnt),
    .buf_full   (buf_full),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_probe   (rd_probe),
    .rd_last    (rd_last)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_busy [NP];
  int m_hold [NP];
  int m_drop [NP];
  int q_data [$];
  int q_src  [$];
  bit m_drain;
  int rank_v [NP];
  int read_log [$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pick_winner();
    int w = -1;
    if (q_data.size() == DEP) return -1;
    for (int r = (1 << RW) - 1; r >= 0; r--)
      for (int i = 0; i < NP; i++)
        if (w < 0 && m_busy[i] && rank_v[i] == r) w = i;
    return w;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_busy[i] = 0; m_hold[i] = 0; m_drop[i] = 0;
    end
    q_data.delete(); q_src.delete();
    m_drain = 0;
  endtask

  task automatic compare_all();
    int  w;
    bit  ev, el;
    w  = pick_winner();
    ev = m_drain && (q_data.size() > 0);
    el = ev && (q_data.size() == 1) && (w < 0);
    check("R6 buf_full", buf_full, (q_data.size() == DEP));
    check("R8 rd_valid", rd_valid, ev);
    check("R9 rd_last", rd_last, el);
    if (ev) begin
      check("R8 rd_data order", rd_data, q_data[0]);
      check("R7 rd_probe", rd_probe, q_src[0]);
      read_log.push_back(int'(rd_probe));
    end
    for (int i = 0; i < NP; i++) begin
      check("R2 R3 probe_busy", probe_busy[i], m_busy[i]);
      check("R4 R5 drop_cnt", drop_cnt[i*CW +: CW], m_drop[i]);
    end
  endtask

  task automatic model_step();
    int  w;
    bit  full, rdf, lastf;
    bit  old_busy [NP];
    w     = pick_winner();
    full  = (q_data.size() == DEP);
    rdf   = m_drain && (q_data.size() > 0);
    lastf = rdf && (q_data.size() == 1) && (w < 0);
    for (int i = 0; i < NP; i++) old_busy[i] = m_busy[i];
    if (rdf) begin
      void'(q_data.pop_front());
      void'(q_src.pop_front());
    end
    if (w >= 0) begin
      q_data.push_back(m_hold[w]);
      q_src.push_back(w);
      m_busy[w] = 0;
    end
    for (int i = 0; i < NP; i++) begin
      if (probe_evt[i]) begin
        if (old_busy[i] || full) begin
          if (m_drop[i] < CMAX) m_drop[i]++;
        end else begin
          m_busy[i] = 1;
          m_hold[i] = int'(probe_din[i*DW +: DW]);
        end
      end
    end
    if (m_drain) begin
      if (lastf) m_drain = 0;
    end else if (burst_req && q_data.size() + (rdf ? 1 : 0) > 0) begin
      m_drain = (full || q_data.size() > 0 || w >= 0) ? (q_data.size() + (rdf ? 1 : 0) - (w >= 0 ? 1 : 0) > 0) : 0;
    end
  endtask

  // one cycle: compare model against DUT, apply inputs, advance model
  task automatic tick(input logic [NP-1:0] ev, input int base, input bit burst);
    @(negedge clk);
    compare_all();
    probe_evt = ev;
    for (int i = 0; i < NP; i++) probe_din[i*DW +: DW] = DW'(base + i);
    burst_req = burst;
    model_step();
  endtask

  task automatic set_ranks(input int r0, input int r1, input int r2, input int r3);
    rank_v[0] = r0; rank_v[1] = r1; rank_v[2] = r2; rank_v[3] = r3;
    for (int i = 0; i < NP; i++) probe_rank[i*RW +: RW] = RW'(rank_v[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_ranks(0, 0, 0, 0);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 buf_full", buf_full, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 probe_busy", probe_busy, 0);
    check("R1 drop_cnt", drop_cnt, 0);
    rst_n = 1'b1;

    // R2 R7: one sample from probe 2, then drain (R8 R9)
    tick(4'b0100, 8'h20, 0);
    tick(4'b0000, 0, 0);
    tick(4'b0000, 0, 0);
    read_log.delete();
    tick(4'b0000, 0, 1);
    repeat (4) tick(4'b0000, 0, 0);
    check("R7 single entry source", (read_log.size() == 1) ? read_log[0] : -1, 2);

    // R3: all probes at once, ranks 1,3,3,0 -> order 1,2,0,3; R4 drops on repeat
    set_ranks(1, 3, 3, 0);
    tick(4'b1111, 8'h40, 0);
    tick(4'b1111, 8'h50, 0);
    repeat (4) tick(4'b0000, 0, 0);
    read_log.delete();
    tick(4'b0000, 0, 1);
    repeat (6) tick(4'b0000, 0, 0);
    check("R3 grant order size", read_log.size(), 4);
    if (read_log.size() == 4) begin
      check("R3 first rank3 low index", read_log[0], 1);
      check("R3 second rank3", read_log[1], 2);
      check("R3 third rank1", read_log[2], 0);
      check("R3 fourth rank0", read_log[3], 3);
    end

    // R6 R5: overfill the store, hammer probe 0 until its counter saturates
    set_ranks(0, 0, 0, 0);
    for (int k = 0; k < 6; k++) tick(4'b1111, 8'h60 + 8*k, 0);
    for (int k = 0; k < 10; k++) tick(4'b0001, 8'h90 + k, 0);
    tick(4'b0000, 0, 0);
    @(negedge clk);
    check("R5 saturated counter", drop_cnt[0 +: CW], CMAX);
    check("R6 full after overfill", buf_full, 1);
    model_step_idle();

    // R8 R10 R11: drain with a repeated burst request and events during drain
    tick(4'b0000, 0, 1);
    tick(4'b0000, 0, 1);
    tick(4'b1000, 8'hA0, 0);
    tick(4'b0000, 0, 0);
    tick(4'b0100, 8'hB0, 0);
    for (int k = 0; k < 12; k++) tick(4'b0000, 0, 0);

    // R10: burst request with an empty store
    tick(4'b0000, 0, 1);
    for (int k = 0; k < 4; k++) tick(4'b0000, 0, 0);
    @(negedge clk);
    check("R10 idle after empty burst", rd_valid, 0);

    // R1: reset in mid-run clears counters
    tick(4'b0011, 8'hC0, 0);
    tick(4'b0011, 8'hC0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    probe_evt = '0;
    model_reset();
    @(negedge clk);
    check("R1 drop_cnt after reset", drop_cnt, 0);
    check("R1 busy after reset", probe_busy, 0);
    rst_n = 1'b1;
    tick(4'b0000, 0, 0);
    tick(4'b0000, 0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // the extra negedge above consumed one cycle with idle inputs
  task automatic model_step_idle();
    model_step();
  endtask

endmodule